// File: doc/BRIEF.md
# Dual-Loop Lock Detector

This block decides whether two phase-locked loops, a main loop and an auxiliary loop, are in lock. It watches each loop's phase/frequency detector pump-up and pump-down pulses on a clock running at the reference input rate. It also watches a per-loop comparison tick that marks the end of each phase comparison. A comparison in which no pump pulse lasts long enough to be sampled is one where the phase error stayed below one reference clock period, so it counts as in lock. Any sampled pump activity marks that comparison out of lock.

Each loop declares lock only after a run of clean comparisons. A single bad comparison clears the lock. The two loop results are merged into one lock pin. A powered-down loop steps aside and lets the other loop decide. With both loops down, the pin reads low. A 2-bit mode selects a combined or single-loop report and a push-pull or open-drain drive. For open-drain drive, the block provides an output-enable for the pad.

Top module: `dual_lock_detect`

## Requirements
- R1: A comparison counts as out of lock if the loop's up or down pulse is high at any rising clock edge from the edge after the previous tick up to and including the edge that samples the tick.
- R2: A powered loop's lock flag rises at the edge that samples the 4th consecutive in-lock tick, and not earlier.
- R3: An out-of-lock tick clears that loop's lock flag at the edge that samples it and restarts the run of 4.
- R4: A loop whose power flag is 0 (1 = powered) has its lock flag and run cleared, so after power returns it needs 4 fresh in-lock ticks.
- R5: Mode 2'b00 drives lock_o with the AND of the two loop results, with lock_oe_o = 1.
- R6: In modes 2'b00 and 2'b01, a powered-down loop counts as locked, so the other loop alone decides the combined result.
- R7: With both power flags 0, lock_o = 0 and lock_oe_o = 1 in every mode.
- R8: Mode 2'b01 (open-drain) holds lock_o = 0 and sets lock_oe_o to the inverse of the combined result: the pin is pulled low when unlocked and released when locked.
- R9: Mode 2'b10 reports the main loop flag alone and mode 2'b11 the aux loop flag alone, both with lock_oe_o = 1. A powered-down selected loop reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference-rate clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| main_up_i | input | 1 | Main detector pump-up pulse |
| main_dn_i | input | 1 | Main detector pump-down pulse |
| main_tick_i | input | 1 | Main comparison end strobe |
| main_pwr_i | input | 1 | Main loop powered (1) |
| aux_up_i | input | 1 | Aux detector pump-up pulse |
| aux_dn_i | input | 1 | Aux detector pump-down pulse |
| aux_tick_i | input | 1 | Aux comparison end strobe |
| aux_pwr_i | input | 1 | Aux loop powered (1) |
| mode_i | input | 2 | Report and drive mode |
| lock_o | output | 1 | Lock pin data |
| lock_oe_o | output | 1 | Lock pin output enable |

## Verification
The per-loop lock flag is a register. A tick or pump pulse driven before a rising edge shows up on the outputs right after that edge, so one cycle after the stimulus. The mode and power flags reach the outputs through logic alone, so they take effect in the same cycle. The bench drives all inputs on falling edges and reads the outputs on the next falling edge. That reads a tick's effect half a cycle after the edge that registers it, and reads a mode or power change before any further edge could move the state.

// File: rtl/lock_det_pkg.sv
package lock_det_pkg;
  typedef enum logic [1:0] {
    MODE_ALL_PP = 2'b00,
    MODE_ALL_OD = 2'b01,
    MODE_MAIN   = 2'b10,
    MODE_AUX    = 2'b11
  } lock_mode_e;

  localparam int unsigned NUM_LOOPS   = 2;
  localparam int unsigned LOOP_MAIN   = 0;
  localparam int unsigned LOOP_AUX    = 1;
  localparam int unsigned RUN_DEFAULT = 4;
endpackage

// File: rtl/loop_lock_judge.sv
module loop_lock_judge #(
  parameter int unsigned LOCK_RUN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_i,
  input  logic up_i,
  input  logic dn_i,
  input  logic tick_i,
  output logic locked_o
);
  localparam int unsigned CW = $clog2(LOCK_RUN + 1);
  localparam logic [CW-1:0] RUN_FULL = CW'(LOCK_RUN);
  localparam logic [CW-1:0] RUN_LAST = CW'(LOCK_RUN - 1);

  logic [CW-1:0] run_q;
  logic          err_q;
  logic          locked_q;
  logic          err_now;
  logic          bad_cmp;

  assign err_now = up_i | dn_i;
  assign bad_cmp = err_q | err_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= '0;
      err_q    <= 1'b0;
      locked_q <= 1'b0;
    end else if (!pwr_i) begin
      run_q    <= '0;
      err_q    <= 1'b0;
      locked_q <= 1'b0;
    end else if (tick_i) begin
      err_q <= 1'b0;
      if (bad_cmp) begin
        run_q    <= '0;
        locked_q <= 1'b0;
      end else if (run_q != RUN_FULL) begin
        run_q <= run_q + 1'b1;
        if (run_q == RUN_LAST) locked_q <= 1'b1;
      end
    end else if (err_now) begin
      err_q <= 1'b1;
    end
  end

  assign locked_o = locked_q;

  // R3: a tick with live pump activity leaves the loop unlocked
  a_r3_bad_tick_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_i && tick_i && err_now) |=> !locked_o);
  // R2: lock only appears on a tick
  a_r2_rise_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(tick_i && pwr_i));
  // R4: power-down clears the flag
  a_r4_pd_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_i |=> !locked_o);
endmodule

// File: rtl/lock_out_mux.sv
module lock_out_mux
  import lock_det_pkg::*;
(
  input  logic       main_lock_i,
  input  logic       aux_lock_i,
  input  logic       main_pwr_i,
  input  logic       aux_pwr_i,
  input  logic [1:0] mode_i,
  output logic       lock_o,
  output logic       lock_oe_o
);
  logic main_ok, aux_ok, combined;

  // a powered-down loop steps aside; both down forces unlocked
  assign main_ok  = main_lock_i | ~main_pwr_i;
  assign aux_ok   = aux_lock_i  | ~aux_pwr_i;
  assign combined = main_ok & aux_ok & (main_pwr_i | aux_pwr_i);

  always_comb begin
    lock_o    = 1'b0;
    lock_oe_o = 1'b1;
    unique case (lock_mode_e'(mode_i))
      MODE_ALL_PP: lock_o    = combined;
      MODE_ALL_OD: lock_oe_o = ~combined;
      MODE_MAIN:   lock_o    = main_lock_i & main_pwr_i;
      MODE_AUX:    lock_o    = aux_lock_i & aux_pwr_i;
      default:     lock_o    = 1'b0;
    endcase
  end
endmodule

// File: rtl/dual_lock_detect.sv
module dual_lock_detect
  import lock_det_pkg::*;
#(
  parameter int unsigned LOCK_RUN = RUN_DEFAULT
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       main_up_i,
  input  logic       main_dn_i,
  input  logic       main_tick_i,
  input  logic       main_pwr_i,
  input  logic       aux_up_i,
  input  logic       aux_dn_i,
  input  logic       aux_tick_i,
  input  logic       aux_pwr_i,
  input  logic [1:0] mode_i,
  output logic       lock_o,
  output logic       lock_oe_o
);
  logic [NUM_LOOPS-1:0] up_v, dn_v, tick_v, pwr_v, locked_v;

  assign up_v   = {aux_up_i,   main_up_i};
  assign dn_v   = {aux_dn_i,   main_dn_i};
  assign tick_v = {aux_tick_i, main_tick_i};
  assign pwr_v  = {aux_pwr_i,  main_pwr_i};

  for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_loop
    loop_lock_judge #(.LOCK_RUN(LOCK_RUN)) u_judge (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pwr_i   (pwr_v[g]),
      .up_i    (up_v[g]),
      .dn_i    (dn_v[g]),
      .tick_i  (tick_v[g]),
      .locked_o(locked_v[g])
    );
  end

  lock_out_mux u_mux (
    .main_lock_i(locked_v[LOOP_MAIN]),
    .aux_lock_i (locked_v[LOOP_AUX]),
    .main_pwr_i (main_pwr_i),
    .aux_pwr_i  (aux_pwr_i),
    .mode_i     (mode_i),
    .lock_o     (lock_o),
    .lock_oe_o  (lock_oe_o)
  );

  // R7: both loops down reads low, driven
  a_r7_both_down_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!main_pwr_i && !aux_pwr_i) |-> (!lock_o && lock_oe_o));
  // R8: open-drain never drives high
  a_r8_od_never_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01) |-> !lock_o);
  // R9 / R5: push-pull modes always enable the pad
  a_r9_pp_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'b01) |-> lock_oe_o);
  // R5: combined high needs both powered loops locked
  a_r5_and_rule: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00 && lock_o && main_pwr_i && aux_pwr_i) |-> (locked_v == 2'b11));
endmodule

// File: tb/tb_dual_lock_detect.sv
`timescale 1ns/1ps
module tb_dual_lock_detect;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_up = 0, m_dn = 0, m_tick = 0, m_pwr = 1;
  logic a_up = 0, a_dn = 0, a_tick = 0, a_pwr = 1;
  logic [1:0] mode = 2'b00;
  logic lock, lock_oe;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dual_lock_detect dut (
    .clk_i(clk), .rst_ni(rst_n),
    .main_up_i(m_up), .main_dn_i(m_dn), .main_tick_i(m_tick), .main_pwr_i(m_pwr),
    .aux_up_i(a_up), .aux_dn_i(a_dn), .aux_tick_i(a_tick), .aux_pwr_i(a_pwr),
    .mode_i(mode), .lock_o(lock), .lock_oe_o(lock_oe)
  );

  task automatic check(input string req, input logic exp_l, input logic exp_oe);
    checks++;
    if (lock !== exp_l || lock_oe !== exp_oe) begin
      errors++;
      $display("FAIL %s: lock=%b oe=%b expected lock=%b oe=%b", req, lock, lock_oe, exp_l, exp_oe);
    end
  endtask

  // one comparison per loop; errors ride on the tick cycle
  task automatic compare(input logic do_m, input logic m_err, input logic do_a, input logic a_err);
    @(negedge clk);
    m_tick = do_m; m_up = m_err;
    a_tick = do_a; a_dn = a_err;
    @(negedge clk);
    m_tick = 0; m_up = 0; a_tick = 0; a_dn = 0;
  endtask

  task automatic t_reset;
    check("R5 reset", 1'b0, 1'b1);
  endtask

  task automatic t_lock_run;
    for (int i = 0; i < 3; i++) compare(1, 0, 1, 0);
    check("R2 three clean", 1'b0, 1'b1);
    compare(1, 0, 1, 0);
    check("R2 fourth clean", 1'b1, 1'b1);
  endtask

  task automatic t_drop_restart;
    compare(1, 1, 1, 0);
    check("R3 bad tick drops", 1'b0, 1'b1);
    for (int i = 0; i < 3; i++) compare(1, 0, 0, 0);
    check("R3 run restarted", 1'b0, 1'b1);
    compare(1, 0, 0, 0);
    check("R3 relocked", 1'b1, 1'b1);
  endtask

  task automatic t_between_ticks;
    @(negedge clk); a_dn = 1;
    @(negedge clk); a_dn = 0;
    repeat (2) @(negedge clk);
    check("R1 no tick yet", 1'b1, 1'b1);
    compare(0, 0, 1, 0);
    check("R1 pulse between ticks", 1'b0, 1'b1);
  endtask

  task automatic t_single_modes;
    mode = 2'b10; #1;
    check("R9 main only", 1'b1, 1'b1);
    mode = 2'b11; #1;
    check("R9 aux only", 1'b0, 1'b1);
  endtask

  task automatic t_open_drain;
    mode = 2'b01; #1;
    check("R8 od unlocked pulls low", 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) compare(0, 0, 1, 0);
    check("R8 od locked releases", 1'b0, 1'b0);
  endtask

  task automatic t_one_down;
    mode = 2'b00;
    @(negedge clk); a_pwr = 0; #1;
    check("R6 aux down main decides", 1'b1, 1'b1);
    mode = 2'b11; #1;
    check("R9 selected loop down", 1'b0, 1'b1);
    mode = 2'b00;
    compare(1, 1, 0, 0);
    check("R6 main bad with aux down", 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) compare(1, 0, 0, 0);
    check("R6 main relocked alone", 1'b1, 1'b1);
    a_pwr = 1; #1;
    check("R4 aux back needs run", 1'b0, 1'b1);
    for (int i = 0; i < 3; i++) compare(0, 0, 1, 0);
    check("R4 aux three clean", 1'b0, 1'b1);
    compare(0, 0, 1, 0);
    check("R4 aux fourth clean", 1'b1, 1'b1);
  endtask

  task automatic t_both_down;
    @(negedge clk); m_pwr = 0; a_pwr = 0; #1;
    check("R7 both down pp", 1'b0, 1'b1);
    mode = 2'b01; #1;
    check("R7 both down od", 1'b0, 1'b1);
    mode = 2'b10; #1;
    check("R7 both down main", 1'b0, 1'b1);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not end");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lock_run();
    t_drop_restart();
    t_between_ticks();
    t_single_modes();
    t_open_drain();
    t_one_down();
    t_both_down();
    finish_run();
  end
endmodule